// File: doc/BRIEF.md
# Streaming Matrix Transposer

This block takes a continuous stream of matrix elements, one word per clock, with each matrix supplied row by row. It returns the same words column by column, so every N_ROWS x N_COLS matrix leaves the block transposed. Matrices may follow each other with no idle cycle between them. Once the first matrix has filled the storage, the output is a gapless stream as well. The word width and both dimensions are parameters, and rectangular shapes are handled as well as square ones. The data words pass through unaltered.

Storage holds two matrices. One half is filled with matrix k+1 while matrix k is read out of the other half. The roles of the two halves swap on the clock edge that accepts the last word of a matrix. An output valid flag marks the transposed words, so a consumer can lock onto the stream without searching for data values.

Top module: `mtx_transpose_stream`

## Requirements
- R1: On every rising clock edge where `stream_en` is high and `rst` is low, the word on `din` is accepted. Words form matrices in row-major order: the first N_COLS words are row 0, the next N_COLS words are row 1, and so on, until N_ROWS*N_COLS words make one matrix.
- R2: Each matrix is emitted in column-major order. Within a matrix, the element at row r and column c is the output word at position c*N_ROWS + r.
- R3: With an uninterrupted enable, output word j (counted from 0 across all matrices) is on `dout` with `dout_vld` high right after the clock edge that accepts input word N_ROWS*N_COLS + j (counted from 0).
- R4: When matrices arrive back to back, `dout_vld` stays high without a gap from the first transposed word to the last word of the final complete matrix.
- R5: Rectangular shapes are supported (default 4 rows by 8 columns). Every word leaves the block bit for bit as it entered.
- R6: While `rst` is high, and on the first cycle after it, `dout` is zero and `dout_vld` is low. A reset in the middle of a stream discards the matrices in flight.
- R7: `dout_vld` stays low until one complete matrix has been accepted.
- R8: A word presented while `stream_en` is low is ignored. It is not stored and does not advance the position within the matrix.
- R9: When input stops after a complete matrix, that matrix still drains completely. `dout_vld` then falls, and `dout` keeps the last emitted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stream_en | input | 1 | Accept the word on din this cycle |
| din | input | DATA_W | Input element, row-major order |
| dout | output | DATA_W | Output element, column-major order, registered |
| dout_vld | output | 1 | dout carries a transposed element |

## Verification
The bench uses a 4 x 8 shape. On this shape, a design that swaps row and column strides, or loops over rows in the outer loop, produces words in the wrong positions even though each matrix still contains the right set of words. A table of element positions is checked in all four back-to-back matrices to catch that. The first valid word must arrive exactly one matrix after the start, and the stream must have no gaps; a design that swaps banks one cycle late shifts or punches holes in the output. A pause of the enable with junk on the input must leave no trace in the output. The last matrix must drain fully after input stops, and a reset in mid-stream must clear the output.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  // Width of a counter that must hold values 0..n-1 (at least 1 bit)
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/mtx_wr_ctrl.sv
module mtx_wr_ctrl
  import mtx_pkg::*;
#(
  parameter int N_ROWS = 4,
  parameter int N_COLS = 8,
  localparam int RW = cnt_w(N_ROWS),
  localparam int CW = cnt_w(N_COLS),
  localparam int AW = cnt_w(N_ROWS * N_COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wr_bank,
  output logic          swap
);
  localparam logic [RW-1:0] ROW_LAST = RW'(N_ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(N_COLS - 1);
  localparam logic [AW-1:0] STRIDE   = AW'(N_COLS);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          bank_q;
  logic          at_end;

  assign at_end  = (row_q == ROW_LAST) && (col_q == COL_LAST);
  assign swap    = wr_en && at_end;
  assign wr_bank = bank_q;
  // row-major placement: row stride is one full row
  assign wr_addr = AW'(row_q) * STRIDE + AW'(col_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      col_q  <= '0;
      bank_q <= 1'b0;
    end else if (wr_en) begin
      if (col_q == COL_LAST) begin
        col_q <= '0;
        if (row_q == ROW_LAST) begin
          row_q  <= '0;
          bank_q <= ~bank_q;
        end else begin
          row_q <= row_q + 1'b1;
        end
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtx_rd_ctrl.sv
module mtx_rd_ctrl
  import mtx_pkg::*;
#(
  parameter int N_ROWS = 4,
  parameter int N_COLS = 8,
  localparam int RW = cnt_w(N_ROWS),
  localparam int CW = cnt_w(N_COLS),
  localparam int AW = cnt_w(N_ROWS * N_COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swap,
  input  logic          filled_bank,
  output logic [AW-1:0] rd_addr,
  output logic          rd_bank,
  output logic          rd_active
);
  localparam logic [RW-1:0] ROW_LAST = RW'(N_ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(N_COLS - 1);
  localparam logic [AW-1:0] STRIDE   = AW'(N_COLS);

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic          bank_q;
  logic          act_q;

  assign rd_bank   = bank_q;
  assign rd_active = act_q;
  // column outer, row inner: same placement, walked down each column
  assign rd_addr   = AW'(row_q) * STRIDE + AW'(col_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      col_q  <= '0;
      bank_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (swap) begin
      // a freshly filled bank takes over; this coincides with the last
      // read of the previous matrix when the stream is unbroken
      row_q  <= '0;
      col_q  <= '0;
      bank_q <= filled_bank;
      act_q  <= 1'b1;
    end else if (act_q) begin
      if (row_q == ROW_LAST) begin
        row_q <= '0;
        if (col_q == COL_LAST) begin
          col_q <= '0;
          act_q <= 1'b0;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end else begin
        row_q <= row_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtx_pingpong_ram.sv
module mtx_pingpong_ram
  import mtx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int AW    = cnt_w(DEPTH),
  localparam int WORDS = 2 ** (AW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              wbank,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic              rbank,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvld
);
  // one simple dual-port array; the bank select is the top address bit
  logic [DATA_W-1:0] mem [0:WORDS-1];

  always_ff @(posedge clk) begin
    if (we) mem[{wbank, waddr}] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      rvld  <= 1'b0;
    end else begin
      rvld <= re;
      if (re) rdata <= mem[{rbank, raddr}];
    end
  end
endmodule

// File: rtl/mtx_transpose_stream.sv
module mtx_transpose_stream
  import mtx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_ROWS = 4,
  parameter int N_COLS = 8,
  localparam int DEPTH = N_ROWS * N_COLS,
  localparam int AW    = cnt_w(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stream_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld
);
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic          wr_bank;
  logic          rd_bank;
  logic          rd_active;
  logic          swap;
  logic          wr_en;

  assign wr_en = stream_en;

  mtx_wr_ctrl #(.N_ROWS(N_ROWS), .N_COLS(N_COLS)) u_wr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bank (wr_bank),
    .swap    (swap)
  );

  mtx_rd_ctrl #(.N_ROWS(N_ROWS), .N_COLS(N_COLS)) u_rd (
    .clk         (clk),
    .rst         (rst),
    .swap        (swap),
    .filled_bank (wr_bank),
    .rd_addr     (rd_addr),
    .rd_bank     (rd_bank),
    .rd_active   (rd_active)
  );

  mtx_pingpong_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .wbank (wr_bank),
    .waddr (wr_addr),
    .wdata (din),
    .re    (rd_active),
    .rbank (rd_bank),
    .raddr (rd_addr),
    .rdata (dout),
    .rvld  (dout_vld)
  );
endmodule

// File: rtl/mtx_transpose_chk.sv
module mtx_transpose_chk #(
  parameter int DATA_W = 16,
  parameter int N_ROWS = 4,
  parameter int N_COLS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              stream_en,
  input logic [DATA_W-1:0] dout,
  input logic              dout_vld,
  input logic              rd_bank,
  input logic              wr_bank,
  input logic              rd_active
);
  localparam int DEPTH = N_ROWS * N_COLS;

  // saturating count of accepted words, used for the fill window
  int unsigned acc_cnt;
  always_ff @(posedge clk) begin
    if (rst) acc_cnt <= 0;
    else if (stream_en && acc_cnt <= DEPTH) acc_cnt <= acc_cnt + 1;
  end

  p_reset_idle_r6: assert property (@(posedge clk)
    $past(rst) |-> (!dout_vld && dout == '0));

  p_fill_first_r7: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> (acc_cnt > DEPTH));

  p_banks_apart_r4: assert property (@(posedge clk) disable iff (rst)
    rd_active |-> (rd_bank != wr_bank));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!dout_vld ##1 !dout_vld) |-> $stable(dout));
endmodule

bind mtx_transpose_stream mtx_transpose_chk #(
  .DATA_W(DATA_W), .N_ROWS(N_ROWS), .N_COLS(N_COLS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stream_en (stream_en),
  .dout      (dout),
  .dout_vld  (dout_vld),
  .rd_bank   (rd_bank),
  .wr_bank   (wr_bank),
  .rd_active (rd_active)
);

// File: tb/sim_mtx_transpose_stream.sv
module sim_mtx_transpose_stream;
  localparam int DW = 16;
  localparam int NR = 4;
  localparam int NC = 8;
  localparam int NE = NR * NC;
  localparam int NMAT = 4;

  // {row, col, expected output position within its matrix}
  localparam int TBL [8][3] = '{
    '{0, 0, 0}, '{0, 1, 4}, '{1, 0, 1}, '{3, 7, 31},
    '{2, 5, 22}, '{1, 3, 13}, '{3, 0, 3}, '{0, 7, 28}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_vld;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DW-1:0] got [0:255];
  int nv, acc, scnt, first_acc, first_s, last_s;
  bit cap;

  always #5 clk = ~clk;

  mtx_transpose_stream #(.DATA_W(DW), .N_ROWS(NR), .N_COLS(NC)) u0 (
    .clk(clk), .rst(rst), .stream_en(en), .din(din),
    .dout(dout), .dout_vld(dout_vld)
  );

  function automatic logic [DW-1:0] gen(input int i);
    return DW'((i * 7 + 3) & 16'hFFFF);
  endfunction

  // expected value of output word j for a stream built from gen(base+i)
  function automatic logic [DW-1:0] expect_out(input int base, input int j);
    int m, p;
    m = j / NE;
    p = j % NE;
    return gen(base + m * NE + (p % NR) * NC + (p / NR));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic [DW-1:0] d);
    @(negedge clk);
    if (cap && dout_vld) begin
      if (nv == 0) begin
        first_acc = acc;
        first_s = scnt;
      end
      last_s = scnt;
      got[nv] = dout;
      nv++;
    end
    scnt++;
    en = e;
    din = d;
    if (e && !rst) acc++;
  endtask

  task automatic clear_capture();
    nv = 0; acc = 0; scnt = 0; first_acc = -1; first_s = 0; last_s = 0;
  endtask

  initial begin
    int bad;
    cap = 1'b0;
    clear_capture();
    // reset state (R6)
    rst = 1'b1;
    repeat (4) step(1'b0, '0);
    @(negedge clk);
    check(dout == '0, "R6 dout in reset", int'(dout), 0);
    check(dout_vld == 1'b0, "R6 vld in reset", int'(dout_vld), 0);
    rst = 1'b0;
    repeat (3) step(1'b0, 16'h5A5A);
    check(dout_vld == 1'b0, "R7 vld before any data", int'(dout_vld), 0);

    // four back-to-back matrices
    clear_capture();
    cap = 1'b1;
    for (int i = 0; i < NMAT * NE; i++) step(1'b1, gen(i));
    for (int i = 0; i < NE + 6; i++) step(1'b0, 16'hFFFF);
    check(nv == NMAT * NE, "R9 all matrices drained", nv, NMAT * NE);
    check(first_acc == NE + 1, "R3 first output latency", first_acc, NE + 1);
    check(last_s - first_s + 1 == nv, "R4 gapless output", last_s - first_s + 1, nv);
    for (int m = 0; m < NMAT; m++) begin
      for (int t = 0; t < 8; t++) begin
        int idx, ev;
        idx = m * NE + TBL[t][2];
        ev = int'(gen(m * NE + TBL[t][0] * NC + TBL[t][1]));
        check(got[idx] == DW'(ev), "R2 column-major position", int'(got[idx]), ev);
      end
    end
    bad = 0;
    for (int j = 0; j < NMAT * NE; j++) if (got[j] != expect_out(0, j)) bad++;
    check(bad == 0, "R1 R5 full stream words", bad, 0);
    check(dout_vld == 1'b0, "R9 vld low after drain", int'(dout_vld), 0);
    check(dout == gen(NMAT * NE - 1), "R9 dout holds last word",
          int'(dout), int'(gen(NMAT * NE - 1)));

    // reset in mid-stream (R6)
    cap = 1'b0;
    for (int i = 0; i < NE + 8; i++) step(1'b1, gen(700 + i));
    check(dout_vld == 1'b1, "R6 stream active before reset", int'(dout_vld), 1);
    rst = 1'b1;
    step(1'b0, '0);
    step(1'b0, '0);
    check(dout == '0 && dout_vld == 1'b0, "R6 mid-stream reset clears",
          int'(dout), 0);
    rst = 1'b0;

    // pause with junk on din (R8)
    clear_capture();
    cap = 1'b1;
    for (int i = 0; i < 2 * NE; i++) begin
      if (i == 10 || i == NE + 3) begin
        for (int k = 0; k < 5; k++) step(1'b0, 16'hDEAD);
      end
      step(1'b1, gen(500 + i));
    end
    for (int i = 0; i < NE + 6; i++) step(1'b0, 16'hBEEF);
    check(nv == 2 * NE, "R8 word count with pause", nv, 2 * NE);
    bad = 0;
    for (int j = 0; j < 2 * NE; j++) if (got[j] != expect_out(500, j)) bad++;
    check(bad == 0, "R8 paused words ignored", bad, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule